// File: doc/BRIEF.md
# Stage-Serial Majority Ripple Adder

This block adds two N-bit operands plus a carry-in, one bit position per stage, the way an adder built into a memory array works when each step is one majority evaluation at the sense amplifiers. Each bit's carry is a three-input majority of the two operand bits and the incoming carry. Each bit's sum is a five-input majority of the two operand bits, the incoming carry and two copies of the inverted carry-out. There is no XOR anywhere.

The carry-out of a bit has to exist before that bit's sum can be formed. The block therefore overlaps the work: in each stage it evaluates the carry of one bit and the sum of the bit below it. A full add takes N+1 stages. A start pulse captures the operands while the block is idle. Each advance strobe then performs one stage. After the last stage a one-cycle done pulse marks the result as final.

For every pending stage the block also puts out the six-bit sense-control code that an array would apply for that stage's carry and sum evaluations. Bit order, MSB first, is {L0, /L1, L1, /L0, L2, L3}.

Top module: `stage_serial_adder`

## Requirements
- R1: A synchronous reset clears `sum_out`, `cout_out` and `done` to zero, leaves the block idle, and forces both sense-code outputs to 6'b000000.
- R2: A `start` pulse while idle captures `a_in`, `b_in` and `cin_in`, clears `sum_out` and `cout_out` to zero in the next cycle, and makes the next accepted advance perform stage 1.
- R3: Stage k, for k from 1 to N, evaluates carry c[k] = MAJ(a[k-1], b[k-1], c[k-1]) with c[0] = the captured carry-in. `cout_out` takes c[N] in the cycle after stage N and holds it until the next start or reset.
- R4: Stage k, for k from 2 to N+1, writes `sum_out[k-2]` = MAJ(a, b, c[k-2], ~c[k-1], ~c[k-1]) taken at bit k-2. Bits not yet written read zero.
- R5: After stage N+1, {`cout_out`, `sum_out`} equals a + b + cin. For example, 0xB7AC + 0x4379 + 1 gives sum 0xFB26 with carry-out 0.
- R6: `done` is high for exactly one cycle: the cycle after the advance that performs stage N+1.
- R7: `start` is ignored while an add is in progress. The operands and progress of the running add are unaffected.
- R8: `adv` is ignored while idle. The outputs do not change.
- R9: While stage k ≤ N is pending, `carry_ctl` = {1,0,1,0,~c,c} with c = c[k-1]. At all other times it is 6'b000000.
- R10: While stage k ≥ 2 is pending, `sum_ctl` = {ci,~co,co,~ci,ci,~ci} with ci = c[k-2] and co = c[k-1]. At all other times it is 6'b000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an add with the present operands (idle only) |
| adv | input | 1 | Perform one stage (busy only) |
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| cin_in | input | 1 | Carry-in |
| sum_out | output | N | Sum bits, filled one per stage |
| cout_out | output | 1 | Carry-out of the top bit |
| done | output | 1 | One-cycle completion pulse |
| carry_ctl | output | 6 | Sense code for the pending carry evaluation |
| sum_ctl | output | 6 | Sense code for the pending sum evaluation |

## Verification
The assertions assume three things about the inputs:
- `start` may arrive at any time, including during an add.
- `adv` may be held low for any number of cycles between stages.
- Operands matter only in the cycle where `start` is accepted.

The stimulus checks each of these. It inserts idle gaps between strobes and injects a start with different operands in the middle of an add. It pulses `adv` while idle. It also changes `a_in` and `b_in` after capture, so any late sampling of the operands would show up in the result.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
   typedef logic [5:0] sense_code_t;

   localparam sense_code_t CODE_NONE = 6'b000000;

   // carry evaluation: fixed upper half, AND/OR select from incoming carry
   function automatic sense_code_t carry_code(input logic c);
      return {4'b1010, ~c, c};
   endfunction

   // sum evaluation: steered by incoming carry and the carry already formed
   function automatic sense_code_t sum_code(input logic ci, input logic co);
      return {ci, ~co, co, ~ci, ci, ~ci};
   endfunction
endpackage

// File: rtl/ssa_majority.sv
module ssa_majority #(
   parameter int IN = 3
) (
   input  logic [IN-1:0] v,
   output logic          y
);
   if (IN < 3 || (IN % 2) == 0) begin : g_bad_in
      $error("ssa_majority: IN must be odd and at least 3");
   end

   if (IN == 3) begin : g_maj3
      assign y = (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
   end else begin : g_majn
      assign y = ($countones(v) > (IN / 2));
   end
endmodule

// File: rtl/ssa_sequencer.sv
module ssa_sequencer #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 2)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          adv,
   output logic          busy,
   output logic [CW-1:0] cnt,
   output logic          load,
   output logic          step,
   output logic          done
);
   logic last;

   assign load = start && !busy;
   assign step = adv && busy;
   assign last = step && (cnt == CW'(N));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (step) begin
            cnt <= cnt + CW'(1);
            if (last) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/stage_serial_adder.sv
module stage_serial_adder #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         adv,
   input  logic [N-1:0] a_in,
   input  logic [N-1:0] b_in,
   input  logic         cin_in,
   output logic [N-1:0] sum_out,
   output logic         cout_out,
   output logic         done,
   output logic [5:0]   carry_ctl,
   output logic [5:0]   sum_ctl
);
   import ssa_pkg::*;

   localparam int CW = $clog2(N + 2);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if (N < 1) begin : g_bad_n
      $error("stage_serial_adder: N must be at least 1");
   end

   logic          busy, load, step;
   logic [CW-1:0] cnt;
   logic [N-1:0]  a_q, b_q;
   logic          carry_q, pcin_q, pcout_q;
   logic          do_carry, do_sum;
   logic [IW-1:0] c_idx, s_idx;
   logic          cmaj, smaj;

   ssa_sequencer #(.N(N), .CW(CW)) u_seq (
      .clk(clk), .rst(rst), .start(start), .adv(adv),
      .busy(busy), .cnt(cnt), .load(load), .step(step), .done(done)
   );

   assign do_carry = busy && (cnt < CW'(N));
   assign do_sum   = busy && (cnt != '0);
   assign c_idx    = IW'(cnt);
   assign s_idx    = IW'(cnt - CW'(1));

   ssa_majority #(.IN(3)) u_carry_maj (
      .v({a_q[c_idx], b_q[c_idx], carry_q}),
      .y(cmaj)
   );

   ssa_majority #(.IN(5)) u_sum_maj (
      .v({a_q[s_idx], b_q[s_idx], pcin_q, ~pcout_q, ~pcout_q}),
      .y(smaj)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q      <= '0;
         b_q      <= '0;
         carry_q  <= 1'b0;
         pcin_q   <= 1'b0;
         pcout_q  <= 1'b0;
         sum_out  <= '0;
         cout_out <= 1'b0;
      end else if (load) begin
         a_q      <= a_in;
         b_q      <= b_in;
         carry_q  <= cin_in;
         pcin_q   <= 1'b0;
         pcout_q  <= 1'b0;
         sum_out  <= '0;
         cout_out <= 1'b0;
      end else if (step) begin
         if (do_carry) begin
            carry_q <= cmaj;
            pcin_q  <= carry_q;
            pcout_q <= cmaj;
            if (cnt == CW'(N - 1)) cout_out <= cmaj;
         end
         if (do_sum) sum_out[s_idx] <= smaj;
      end
   end

   assign carry_ctl = do_carry ? carry_code(carry_q)        : CODE_NONE;
   assign sum_ctl   = do_sum   ? sum_code(pcin_q, pcout_q)  : CODE_NONE;
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 2)
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic          adv,
   input logic [N-1:0]  a_in,
   input logic [N-1:0]  b_in,
   input logic          cin_in,
   input logic [N-1:0]  sum_out,
   input logic          cout_out,
   input logic          done,
   input logic [5:0]    carry_ctl,
   input logic [5:0]    sum_ctl,
   input logic          busy,
   input logic [CW-1:0] cnt
);
   logic [N:0] ref_total;

   always_ff @(posedge clk) begin
      if (rst) ref_total <= '0;
      else if (start && !busy)
         ref_total <= {1'b0, a_in} + {1'b0, b_in} + {{N{1'b0}}, cin_in};
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) |-> (sum_out == '0 && !cout_out && !done && carry_ctl == 6'd0 && sum_ctl == 6'd0));

   p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> (sum_out == '0 && !cout_out && busy));

   p_result_r5: assert property (@(posedge clk) disable iff (rst)
      done |-> ({cout_out, sum_out} == ref_total));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
      (adv && busy && cnt == CW'(N)) |=> done);

   p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
      (busy && start && !adv) |=> ($stable(cnt) && busy && $stable(sum_out)));

   p_idle_adv_r8: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start && adv) |=> ($stable(sum_out) && $stable(cout_out)));

   p_codes_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (carry_ctl == 6'd0 && sum_ctl == 6'd0));

   p_sum_follows_carry_r10: assert property (@(posedge clk) disable iff (rst)
      (adv && busy && cnt < CW'(N)) |=> (sum_ctl[5] == $past(carry_ctl[0])));

   p_stage_bound: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(N + 1));
endmodule

bind stage_serial_adder ssa_checker #(.N(N)) i_ssa_checker (
   .clk(clk), .rst(rst), .start(start), .adv(adv),
   .a_in(a_in), .b_in(b_in), .cin_in(cin_in),
   .sum_out(sum_out), .cout_out(cout_out), .done(done),
   .carry_ctl(carry_ctl), .sum_ctl(sum_ctl),
   .busy(busy), .cnt(cnt)
);

// File: tb/test_stage_serial_adder.sv
module test_stage_serial_adder;
   localparam int N = 16;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG = 100000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         adv = 1'b0;
   logic [N-1:0] a_in = '0;
   logic [N-1:0] b_in = '0;
   logic         cin_in = 1'b0;
   logic [N-1:0] sum_out;
   logic         cout_out, done;
   logic [5:0]   carry_ctl, sum_ctl;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   stage_serial_adder #(.N(N)) i_stage_serial_adder (
      .clk(clk), .rst(rst), .start(start), .adv(adv),
      .a_in(a_in), .b_in(b_in), .cin_in(cin_in),
      .sum_out(sum_out), .cout_out(cout_out), .done(done),
      .carry_ctl(carry_ctl), .sum_ctl(sum_ctl)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // behavioural reference model
   bit         m_busy, m_done, m_cin, m_cout;
   int         m_stage;
   logic [N-1:0] m_a, m_b, m_sum;
   logic [N:0]   m_full;

   function automatic bit carry_into(int i);
      if (i >= N) return m_full[N];
      return m_full[i] ^ m_a[i] ^ m_b[i];
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_busy = 0; m_done = 0; m_stage = 0; m_sum = '0; m_cout = 0;
         m_a = '0; m_b = '0; m_cin = 0; m_full = '0;
      end else begin
         m_done = 0;
         if (!m_busy && start) begin
            m_a = a_in; m_b = b_in; m_cin = cin_in;
            m_full = {1'b0, a_in} + {1'b0, b_in} + {{N{1'b0}}, cin_in};
            m_busy = 1; m_stage = 0; m_sum = '0; m_cout = 0;
         end else if (m_busy && adv) begin
            m_stage++;
            if (m_stage >= 2) m_sum[m_stage-2] = m_full[m_stage-2];
            if (m_stage == N) m_cout = m_full[N];
            if (m_stage == N + 1) begin
               m_busy = 0; m_done = 1;
            end
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [5:0] ec, es;
      bit ci, co;
      ec = 6'd0; es = 6'd0;
      if (m_busy && m_stage < N) begin
         ci = carry_into(m_stage);
         ec = {4'b1010, ~ci, ci};
      end
      if (m_busy && m_stage >= 1) begin
         ci = carry_into(m_stage - 1);
         co = carry_into(m_stage);
         es = {ci, ~co, co, ~ci, ci, ~ci};
      end
      check("R4 sum_out per stage", 32'(sum_out), 32'(m_sum));
      check("R3 cout_out", 32'(cout_out), 32'(m_cout));
      check("R6 done", 32'(done), 32'(m_done));
      check("R9 carry_ctl", 32'(carry_ctl), 32'(ec));
      check("R10 sum_ctl", 32'(sum_ctl), 32'(es));
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_op(logic [N-1:0] a, logic [N-1:0] b, logic c, bit gaps, bit inject);
      logic [N:0] want;
      want = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, c};
      a_in = a; b_in = b; cin_in = c; start = 1;
      tick();
      start = 0;
      check("R2 sum cleared on start", 32'(sum_out), 32'd0);
      a_in = ~a; b_in = a ^ b; cin_in = ~c;
      for (int k = 0; k <= N; k++) begin
         if (gaps && (k % 3) == 1) begin
            adv = 0;
            tick();
         end
         if (inject && k == 5) begin
            start = 1; adv = 0;
            tick();
            start = 0;
            check("R7 start ignored while busy", 32'(sum_out[2:0]), 32'(want[2:0]));
         end
         adv = 1;
         tick();
         adv = 0;
      end
      check("R5 final sum", 32'(sum_out), 32'(want[N-1:0]));
      check("R5 final carry", 32'(cout_out), 32'(want[N]));
      check("R6 done after last stage", 32'(done), 32'd1);
      tick();
      check("R6 done one cycle", 32'(done), 32'd0);
   endtask

   initial begin
      repeat (3) tick();
      rst = 0;
      tick();
      check("R1 reset sum", 32'(sum_out), 32'd0);
      check("R1 reset cout", 32'(cout_out), 32'd0);
      check("R1 reset done", 32'(done), 32'd0);
      check("R1 reset codes", 32'({carry_ctl, sum_ctl}), 32'd0);

      do_op(16'hB7AC, 16'h4379, 1'b1, 0, 0);
      check("R5 worked example", 32'({cout_out, sum_out}), 32'h0FB26);
      do_op(16'hFFFF, 16'hFFFF, 1'b1, 1, 0);
      do_op(16'hFFFF, 16'h0000, 1'b1, 0, 1);
      do_op(16'h0000, 16'h0000, 1'b0, 1, 0);
      do_op(16'h8000, 16'h8000, 1'b0, 0, 0);

      // idle strobes must leave the result untouched
      begin
         logic [N-1:0] held;
         held = sum_out;
         adv = 1;
         repeat (3) tick();
         adv = 0;
         tick();
         check("R8 adv ignored while idle", 32'(sum_out), 32'(held));
         check("R8 carry held while idle", 32'(cout_out), 32'd1);
      end

      for (int i = 0; i < 24; i++)
         do_op(N'($urandom), N'($urandom), 1'($urandom), (i % 2) == 0, (i % 5) == 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > WATCHDOG) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule